// File: doc/BRIEF.md
# Dilated-Integer Address Stepper

The block keeps a tile-local Morton-order address as one register per array index. Each index is stored in dilated form, so its bits sit only at the positions that index owns in the interleaved word. A tuple of plain binary indices is loaded once and spread into these lanes. After that, a strobe adds a signed step to one chosen lane. The adder works on the dilated operand directly. The empty positions are padded with ones so that carries jump across them, and the sum is then masked back to the lane. The other lanes are never touched. The offset output is the OR of all lanes, shifted left by the element-size exponent.

Two layouts are supported. In the 2-D layout, index k owns bit positions k, k+2, k+4 and so on, and only lanes 0 and 1 are used. In the 3-D layout, index k owns positions k, k+3, k+6 and so on. The step and a compare bound are loaded through a separate strobe, and the lane-specific operands are prepared at that moment rather than in the cycle of each step. Each step also produces two kinds of flag. One is a wrap flag, set when the index runs off either edge of the tile. The other pair compares the updated index, in its dilated form, against the bound.

Top module: `dil_addr_stepper`

## Requirements
- R1: While rst_n is low, and after its release until the first load, offset, wrap, at_bound and past_bound are all 0.
- R2: A load pulse latches the layout (mode3 = 0 selects 2-D, 1 selects 3-D). It places bit j of index k at address bit k + j·m, with m = 2 or 3. In 2-D, idx2 is ignored. From the next cycle, offset equals that interleaved word times 2^ES. A load clears all three flags.
- R3: A step_ld pulse latches the step and the bound. Both are given as IW-bit values, dilated into the lane-0 positions of the current layout. The step is in two's complement. A step_ld pulse alone does not change offset or the flags, and the new operands are used from the next go.
- R4: A go pulse with a valid step_dim = d sets index d to (index d + step) mod 2^IW, leaving the other indices unchanged. The new offset appears in the cycle after the go.
- R5: In 2-D with ES = 2, loading (3,5) gives offset 156. A go on dimension 0 with a step of 3 then gives offset 216.
- R6: A negative step, for example -1 dilated as all lane-0 positions set, goes through the same adder and decrements modulo 2^IW.
- R7: On a valid go, wrap is set to 1 when a non-negative step makes index + step ≥ 2^IW, or when a negative step makes index + step < 0. Otherwise wrap is set to 0.
- R8: On a valid go, at_bound becomes (new index == bound) and past_bound becomes (new index > bound), both unsigned. The two are never 1 together.
- R9: A go with step_dim ≥ m (2 or 3 in 2-D, 3 in 3-D) changes neither offset nor any flag.
- R10: When load and go are asserted in the same cycle, the load wins and the go is dropped.
- R11: With neither load nor go asserted, offset and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load the index tuple and layout |
| mode3 | input | 1 | Layout select at load: 0 = 2-D, 1 = 3-D |
| idx0 | input | IW | Index 0 at load |
| idx1 | input | IW | Index 1 at load |
| idx2 | input | IW | Index 2 at load (3-D only) |
| step_ld | input | 1 | Latch step and bound |
| step_val | input | 3·IW | Dilated two's-complement step, lane-0 positions |
| bound_val | input | 3·IW | Dilated compare bound, lane-0 positions |
| go | input | 1 | Apply the step to one index |
| step_dim | input | 2 | Index to step |
| offset | output | 3·IW+ES | Interleaved address times element size |
| wrap | output | 1 | Last step crossed a tile edge |
| at_bound | output | 1 | Stepped index equals bound |
| past_bound | output | 1 | Stepped index exceeds bound |

## Verification
The hardest case to reach from the ports is a carry that has to cross the empty positions of its own lane and leave the top of the word, while bits owned by other lanes are sitting in those gaps. An underflow on a negative step is equally hard to reach. The stimulus sweeps every start value against every signed step on every lane in both layouts, with the other lanes loaded non-zero, so that every carry and borrow pattern at the tile edge is exercised. Random walks then chain many steps over mixed dimensions, including invalid ones. They compare each offset against an interleave computed from scratch in the bench.

// File: rtl/dil_addr_pkg.sv
package dil_addr_pkg;

    localparam int NDIM = 3;
    localparam int MAXW = 64;

    typedef enum logic {
        LAYOUT_2D = 1'b0,
        LAYOUT_3D = 1'b1
    } layout_e;

    // Ones at the positions lane k owns when m lanes are interleaved
    function automatic logic [MAXW-1:0] lane_mask(input int k, input int m, input int iw);
        logic [MAXW-1:0] r;
        r = '0;
        for (int j = 0; j < iw; j++) begin
            if (k < m && (k + j * m) < MAXW) r[k + j * m] = 1'b1;
        end
        return r;
    endfunction

    // Spread the low iw bits of v into lane k of an m-way interleave
    function automatic logic [MAXW-1:0] spread(input logic [MAXW-1:0] v, input int k,
                                               input int m, input int iw);
        logic [MAXW-1:0] r;
        r = '0;
        for (int j = 0; j < iw; j++) begin
            if ((k + j * m) < MAXW) r[k + j * m] = v[j];
        end
        return r;
    endfunction

endpackage

// File: rtl/dil_bias_bank.sv
module dil_bias_bank
    import dil_addr_pkg::*;
#(
    parameter int IW = 4,
    localparam int AW = NDIM * IW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_ld,
    input  layout_e                  layout,
    input  logic [AW-1:0]            step_in,
    input  logic [AW-1:0]            bound_in,
    output logic [NDIM-1:0][AW-1:0]  bias,
    output logic [NDIM-1:0][AW-1:0]  bound,
    output logic                     step_neg
);

    localparam int TOP2 = (IW - 1) * 2;
    localparam int TOP3 = (IW - 1) * 3;

    typedef struct packed {
        logic [NDIM-1:0][AW-1:0] bias;
        logic [NDIM-1:0][AW-1:0] bound;
        logic                    neg;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        logic [MAXW-1:0] msk0;
        logic [MAXW-1:0] mskk;
        logic [MAXW-1:0] sv;
        logic [MAXW-1:0] bv;
        int m;
        b_d  = b_q;
        m    = (layout == LAYOUT_3D) ? 3 : 2;
        msk0 = lane_mask(0, m, IW);
        mskk = '0;
        sv   = '0;
        bv   = '0;
        if (step_ld) begin
            for (int k = 0; k < NDIM; k++) begin
                mskk = lane_mask(k, m, IW);
                sv   = (MAXW'(step_in) & msk0) << k;
                bv   = (MAXW'(bound_in) & msk0) << k;
                // step + ~mask: the bits are disjoint, so an OR is enough
                b_d.bias[k]  = sv[AW-1:0] | ~mskk[AW-1:0];
                b_d.bound[k] = bv[AW-1:0];
            end
            b_d.neg = (layout == LAYOUT_3D) ? step_in[TOP3] : step_in[TOP2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign bias     = b_q.bias;
    assign bound    = b_q.bound;
    assign step_neg = b_q.neg;

endmodule

// File: rtl/dil_lane.sv
module dil_lane #(
    parameter int AW = 12
) (
    input  logic [AW-1:0] comp,
    input  logic [AW-1:0] bias,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] bound,
    input  logic          neg,
    output logic [AW-1:0] nxt,
    output logic          wrap,
    output logic          eq,
    output logic          gt
);

    logic [AW:0] sum;

    // Gap positions of bias are ones, so carries ripple across them
    assign sum  = {1'b0, comp} + {1'b0, bias};
    assign nxt  = sum[AW-1:0] & mask;
    // Carry out means overflow for a positive step, no borrow for a negative one
    assign wrap = sum[AW] ^ neg;
    assign eq   = (nxt == bound);
    assign gt   = (nxt > bound);

endmodule

// File: rtl/dil_addr_stepper.sv
module dil_addr_stepper
    import dil_addr_pkg::*;
#(
    parameter int IW = 4,
    parameter int ES = 2,
    localparam int AW = NDIM * IW,
    localparam int OW = AW + ES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          mode3,
    input  logic [IW-1:0] idx0,
    input  logic [IW-1:0] idx1,
    input  logic [IW-1:0] idx2,
    input  logic          step_ld,
    input  logic [AW-1:0] step_val,
    input  logic [AW-1:0] bound_val,
    input  logic          go,
    input  logic [1:0]    step_dim,
    output logic [OW-1:0] offset,
    output logic          wrap,
    output logic          at_bound,
    output logic          past_bound
);

    typedef struct packed {
        layout_e                 layout;
        logic [NDIM-1:0][AW-1:0] comp;
        logic                    wrap;
        logic                    at_b;
        logic                    past_b;
    } st_t;

    st_t st_d, st_q;

    layout_e                 layout_in;
    layout_e                 layout_eff;
    logic [NDIM-1:0][IW-1:0] idx_all;
    logic [NDIM-1:0][AW-1:0] mask_cur;
    logic [NDIM-1:0][AW-1:0] bias;
    logic [NDIM-1:0][AW-1:0] bound;
    logic [NDIM-1:0][AW-1:0] nxt;
    logic [NDIM-1:0]         lw;
    logic [NDIM-1:0]         leq;
    logic [NDIM-1:0]         lgt;
    logic                    step_neg;
    logic                    dim_ok;
    logic [AW-1:0]           merged;
    layout_e                 cur_layout;
    logic [NDIM-1:0][AW-1:0] comp_q;

    assign layout_in  = mode3 ? LAYOUT_3D : LAYOUT_2D;
    assign layout_eff = load ? layout_in : st_q.layout;
    assign idx_all    = {idx2, idx1, idx0};

    dil_bias_bank #(.IW(IW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_ld  (step_ld),
        .layout   (layout_eff),
        .step_in  (step_val),
        .bound_in (bound_val),
        .bias     (bias),
        .bound    (bound),
        .step_neg (step_neg)
    );

    for (genvar k = 0; k < NDIM; k++) begin : g_lane
        localparam logic [MAXW-1:0] M2 = lane_mask(k, 2, IW);
        localparam logic [MAXW-1:0] M3 = lane_mask(k, 3, IW);
        assign mask_cur[k] = (st_q.layout == LAYOUT_3D) ? M3[AW-1:0] : M2[AW-1:0];

        dil_lane #(.AW(AW)) u_lane (
            .comp  (st_q.comp[k]),
            .bias  (bias[k]),
            .mask  (mask_cur[k]),
            .bound (bound[k]),
            .neg   (step_neg),
            .nxt   (nxt[k]),
            .wrap  (lw[k]),
            .eq    (leq[k]),
            .gt    (lgt[k])
        );
    end

    assign dim_ok = (st_q.layout == LAYOUT_3D) ? (step_dim < 2'd3) : (step_dim < 2'd2);

    always_comb begin
        logic [MAXW-1:0] sp;
        logic [MAXW-1:0] mk;
        int m;
        st_d = st_q;
        m    = mode3 ? 3 : 2;
        sp   = '0;
        mk   = '0;
        if (load) begin
            st_d.layout = layout_in;
            for (int k = 0; k < NDIM; k++) begin
                sp = spread(MAXW'(idx_all[k]), k, m, IW);
                mk = lane_mask(k, m, IW);
                st_d.comp[k] = sp[AW-1:0] & mk[AW-1:0];
            end
            st_d.wrap   = 1'b0;
            st_d.at_b   = 1'b0;
            st_d.past_b = 1'b0;
        end else if (go && dim_ok) begin
            for (int k = 0; k < NDIM; k++) begin
                if (step_dim == 2'(k)) begin
                    st_d.comp[k] = nxt[k];
                    st_d.wrap    = lw[k];
                    st_d.at_b    = leq[k];
                    st_d.past_b  = lgt[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        merged = '0;
        for (int k = 0; k < NDIM; k++) merged = merged | st_q.comp[k];
    end

    assign offset     = {merged, {ES{1'b0}}};
    assign wrap       = st_q.wrap;
    assign at_bound   = st_q.at_b;
    assign past_bound = st_q.past_b;
    assign cur_layout = st_q.layout;
    assign comp_q     = st_q.comp;

endmodule

// File: rtl/dil_addr_chk.sv
module dil_addr_chk
    import dil_addr_pkg::*;
#(
    parameter int IW = 4,
    parameter int ES = 2,
    localparam int AW = NDIM * IW,
    localparam int OW = AW + ES
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    load,
    input logic                    go,
    input logic [1:0]              step_dim,
    input layout_e                 cur_layout,
    input logic [NDIM-1:0][AW-1:0] comp_q,
    input logic [OW-1:0]           offset,
    input logic                    wrap,
    input logic                    at_bound,
    input logic                    past_bound
);

    for (genvar k = 0; k < NDIM; k++) begin : g_k
        localparam logic [MAXW-1:0] C2 = lane_mask(k, 2, IW);
        localparam logic [MAXW-1:0] C3 = lane_mask(k, 3, IW);
        logic [AW-1:0] own;
        assign own = (cur_layout == LAYOUT_3D) ? C3[AW-1:0] : C2[AW-1:0];

        // R2
        lane_confined_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (comp_q[k] & ~own) == '0);

        // R4
        other_lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (go && !load && step_dim != 2'(k)) |=> $stable(comp_q[k]));
    end

    // R2
    load_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!wrap && !at_bound && !past_bound));

    // R8
    bound_flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_bound && past_bound));

    // R9
    bad_dim_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !load && step_dim == 2'd3) |=> ($stable(offset) && $stable(wrap)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !load) |=> ($stable(offset) && $stable(wrap) && $stable(at_bound)));

endmodule

bind dil_addr_stepper dil_addr_chk #(.IW(IW), .ES(ES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .go         (go),
    .step_dim   (step_dim),
    .cur_layout (cur_layout),
    .comp_q     (comp_q),
    .offset     (offset),
    .wrap       (wrap),
    .at_bound   (at_bound),
    .past_bound (past_bound)
);

// File: tb/sim_dil_addr_stepper.sv
module sim_dil_addr_stepper;

    localparam int IW = 4;
    localparam int ES = 2;
    localparam int AW = 3 * IW;
    localparam int OW = AW + ES;
    localparam int TOPV = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic          mode3 = 1'b0;
    logic [IW-1:0] idx0 = '0, idx1 = '0, idx2 = '0;
    logic          step_ld = 1'b0;
    logic [AW-1:0] step_val = '0, bound_val = '0;
    logic          go = 1'b0;
    logic [1:0]    step_dim = '0;
    logic [OW-1:0] offset;
    logic          wrap, at_bound, past_bound;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    int  mi [3];
    int  mm = 2;
    int  mstep = 0;
    int  mbnd = 0;
    bit  ewrap = 0, eat = 0, epast = 0;

    always #2 clk = ~clk;

    dil_addr_stepper #(.IW(IW), .ES(ES)) u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .mode3(mode3),
        .idx0(idx0), .idx1(idx1), .idx2(idx2),
        .step_ld(step_ld), .step_val(step_val), .bound_val(bound_val),
        .go(go), .step_dim(step_dim),
        .offset(offset), .wrap(wrap), .at_bound(at_bound), .past_bound(past_bound)
    );

    function automatic int dil(input int v, input int k, input int m);
        int r = 0;
        for (int j = 0; j < IW; j++) if (((v >> j) & 1) != 0) r += (1 << (k + j * m));
        return r;
    endfunction

    function automatic int exp_off();
        int r = 0;
        for (int k = 0; k < mm; k++) r = r | dil(mi[k], k, mm);
        return r * (1 << ES);
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " offset"}, int'(offset), exp_off());
        chk("R7 wrap", int'(wrap), int'(ewrap));
        chk("R8 at_bound", int'(at_bound), int'(eat));
        chk("R8 past_bound", int'(past_bound), int'(epast));
    endtask

    task automatic pulse();
        @(posedge clk);
        #1;
        load = 0; step_ld = 0; go = 0;
    endtask

    task automatic do_load(input int m, input int a, input int b, input int c);
        mode3 = (m == 3); idx0 = IW'(a); idx1 = IW'(b); idx2 = IW'(c);
        load = 1;
        pulse();
        mm = m; mi[0] = a; mi[1] = b; mi[2] = (m == 3) ? c : 0;
        ewrap = 0; eat = 0; epast = 0;
    endtask

    task automatic do_step_ld(input int s, input int bnd);
        step_val  = AW'(dil(s & (TOPV - 1), 0, mm));
        bound_val = AW'(dil(bnd, 0, mm));
        step_ld = 1;
        pulse();
        mstep = s; mbnd = bnd;
        check_all("R3 step_ld alone");
    endtask

    task automatic model_go(input int d);
        int sum;
        if (d < mm) begin
            sum   = mi[d] + mstep;
            ewrap = (mstep >= 0) ? (sum >= TOPV) : (sum < 0);
            mi[d] = sum & (TOPV - 1);
            eat   = (mi[d] == mbnd);
            epast = (mi[d] > mbnd);
        end
    endtask

    task automatic do_go(input int d, input string tag);
        step_dim = 2'(d);
        go = 1;
        pulse();
        model_go(d);
        check_all(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 offset in reset", int'(offset), 0);
        chk("R1 wrap in reset", int'(wrap), 0);
        chk("R1 bound flags in reset", int'(at_bound | past_bound), 0);
        rst_n = 1;
        pulse();
        chk("R1 offset after reset", int'(offset), 0);

        // R5 worked example
        do_load(2, 3, 5, 9);
        chk("R5 load (3,5)", int'(offset), 156);
        do_step_ld(3, 6);
        do_go(0, "R5");
        chk("R5 after +3", int'(offset), 216);
        chk("R8 at bound 6", int'(at_bound), 1);

        // R6 decrement by one
        do_step_ld(-1, 0);
        do_go(1, "R6 minus one");

        // R9 invalid dims in 2-D
        do_go(2, "R9 dim2 in 2-D");
        do_go(3, "R9 dim3 in 2-D");

        // R10 load and go together
        do_load(3, 1, 2, 3);
        do_step_ld(5, 4);
        mode3 = 1; idx0 = 4'd7; idx1 = 4'd8; idx2 = 4'd15;
        load = 1; go = 1; step_dim = 2'd0;
        pulse();
        mm = 3; mi[0] = 7; mi[1] = 8; mi[2] = 15;
        ewrap = 0; eat = 0; epast = 0;
        check_all("R10 load wins");
        do_go(3, "R9 dim3 in 3-D");

        // R11 idle cycles
        pulse(); pulse();
        check_all("R11 idle");

        // R4 R6 R7 R8 sweep: every start, every signed step, every lane
        for (int m = 2; m <= 3; m++) begin
            for (int d = 0; d < m; d++) begin
                for (int st = 0; st < TOPV; st++) begin
                    for (int s = -(TOPV / 2); s < TOPV / 2; s++) begin
                        do_load(m, (d == 0) ? st : 4'hA, (d == 1) ? st : 4'h5, (d == 2) ? st : 4'hF);
                        check_all("R2 load");
                        do_step_ld(s, (st * 7 + s + TOPV) % TOPV);
                        do_go(d, (s < 0) ? "R6 sweep" : "R4 sweep");
                    end
                end
            end
        end

        // R4 random walks over mixed dimensions
        for (int m = 2; m <= 3; m++) begin
            do_load(m, $urandom % TOPV, $urandom % TOPV, $urandom % TOPV);
            do_step_ld(int'($urandom % TOPV) - TOPV / 2, $urandom % TOPV);
            for (int n = 0; n < 600; n++) begin
                if ($urandom % 6 == 0)
                    do_step_ld(int'($urandom % TOPV) - TOPV / 2, $urandom % TOPV);
                do_go($urandom % 4, "R4 walk");
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule